// File: doc/BRIEF.md
# Wake-up clock source switch controller

This controller owns the source choice for one group of clock domains that always share a source: the CPU, system bus and peripheral clocks. A run-time source field drives normal operation. A second field names the source that the group should run from once the system comes out of low power. The block drives a select code to a separate glitch-free clock multiplexer. It also drives one enable line for each of the eight clock sources, and it reads one valid line from each source.

When the wake-up strobe arrives, the controller latches the wake-up field as its target. It then raises the target's enable and keeps the old select code in place until the target reports valid. At that point it moves the select code over, and the run-time field takes the new code, so the select output always matches the source in use. If the target is already enabled and valid, the switch happens at the strobe edge. An optional cycle limit abandons a switch whose source never becomes valid: an error flag is set and the old source stays selected. Domains outside the shared group keep their own selection logic and are not touched here.

Top module: `wake_clk_sel`

## Requirements
- R1: After reset, `dom_sel` is 0, `busy` and `err` are 0, and `src_en` has only bit 0 set.
- R2: A write with `wr_addr` 0 while idle loads `wr_data[2:0]` into the run-time field, and `dom_sel` shows it after one clock edge. The other addresses are: 1 for the wake-up field (`wr_data[2:0]`), 2 for the timeout limit, and 3 for the software enable mask (`wr_data[7:0]`, bit n for source n).
- R3: `src_en` is the OR of three terms: the enable mask, the one-hot bit of the current `dom_sel`, and, while `busy` is set, the one-hot bit of the latched target.
- R4: If the wake-up source is already enabled (mask or current selection) and its valid input is high when the strobe is sampled, `dom_sel` takes the wake-up code at that same edge and `busy` stays 0.
- R5: Otherwise an accepted strobe sets `busy` and `dom_sel` keeps its old value. At the first later edge where the target's valid input is high, `dom_sel` takes the target code and `busy` clears.
- R6: A wake-up strobe while `busy` is ignored. A write to the wake-up field while `busy` leaves the current target alone, but is stored and used by the next strobe.
- R7: Writes to the run-time field while `busy` are ignored.
- R8: With a nonzero limit L, if the target is not valid at any of the L edges after the accepted strobe, `err` is set and `busy` clears at the L-th edge, and `dom_sel` keeps the old source. A limit of 0 means the controller waits without limit.
- R9: An accepted wake-up strobe clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 run, 1 wake, 2 limit, 3 mask |
| wr_data | input | 16 | Write data |
| wake | input | 1 | Wake-up event strobe |
| src_valid | input | 8 | Per-source valid flags |
| src_en | output | 8 | Per-source enable requests |
| dom_sel | output | 3 | Source code for the shared domain multiplexer |
| busy | output | 1 | Wake-up switch in progress |
| err | output | 1 | Last switch abandoned by timeout |

## Verification
The hardest case to reach is a strobe, or a write to either source field, that arrives during the window in which a switch waits on valid. The stimulus opens that window on purpose by holding every valid line low. It then issues a second strobe and writes to both fields inside the window. Next it raises only the valid of the rewritten wake-up code, and the switch must keep waiting. Only after that does it release the original target. The timeout edge is reached by counting cycles from the accepted strobe with the limit programmed to a small value.

// File: rtl/wake_clk_sel.sv
`timescale 1ns/1ps
module wake_clk_sel #(
  parameter int NSRC = 8,
  parameter int DW   = 16,
  parameter int TW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            wake,
  input  logic [NSRC-1:0] src_valid,
  output logic [NSRC-1:0] src_en,
  output logic [$clog2(NSRC)-1:0] dom_sel,
  output logic            busy,
  output logic            err
);
  localparam int CW = $clog2(NSRC);
  localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

  logic [CW-1:0]   run_q, wake_q, tgt_q;
  logic [TW-1:0]   lim_q, cnt_q;
  logic [NSRC-1:0] mask_q;
  logic            busy_q, err_q;

  wire [NSRC-1:0] run_oh  = ONE << run_q;
  wire [NSRC-1:0] wake_oh = ONE << wake_q;
  wire [NSRC-1:0] tgt_oh  = ONE << tgt_q;
  wire accept     = wake && !busy_q;
  wire wake_ready = (|((mask_q | run_oh) & wake_oh)) && src_valid[wake_q];
  wire tgt_ok     = src_valid[tgt_q];
  wire timed_out  = (lim_q != '0) && (cnt_q == lim_q - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      wake_q <= '0;
      tgt_q  <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (!busy_q) run_q <= wr_data[CW-1:0];
          2'd1: wake_q <= wr_data[CW-1:0];
          2'd2: lim_q  <= wr_data[TW-1:0];
          default: mask_q <= wr_data[NSRC-1:0];
        endcase
      end
      if (accept) begin
        err_q <= 1'b0;
        tgt_q <= wake_q;
        cnt_q <= '0;
        if (wake_ready) run_q  <= wake_q;
        else            busy_q <= 1'b1;
      end else if (busy_q) begin
        if (tgt_ok) begin
          run_q  <= tgt_q;
          busy_q <= 1'b0;
        end else if (timed_out) begin
          err_q  <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end
  end

  assign src_en  = mask_q | run_oh | (busy_q ? tgt_oh : '0);
  assign dom_sel = run_q;
  assign busy    = busy_q;
  assign err     = err_q;
endmodule

module wake_clk_sel_chk #(
  parameter int NSRC = 8,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            err,
  input logic [CW-1:0]   dom_sel,
  input logic [NSRC-1:0] src_en,
  input logic [NSRC-1:0] src_valid,
  input logic [CW-1:0]   tgt
);
  assert_run_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_en[dom_sel]);
  assert_target_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> src_en[tgt]);
  assert_hold_while_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !src_valid[tgt]) |=> $stable(dom_sel));
  assert_switch_on_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_valid[tgt]) |=> (!busy && dom_sel == $past(tgt)));
  assert_target_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tgt));
  assert_err_ends_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && $stable(dom_sel)));
endmodule

bind wake_clk_sel wake_clk_sel_chk #(.NSRC(NSRC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .dom_sel(dom_sel),
  .src_en(src_en), .src_valid(src_valid), .tgt(tgt_q)
);

// File: tb/sim_wake_clk_sel.sv
`timescale 1ns/1ps
module sim_wake_clk_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wake = 1'b0;
  logic [7:0]  src_valid = '0;
  logic [7:0]  src_en;
  logic [2:0]  dom_sel;
  logic        busy, err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_clk_sel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake(wake), .src_valid(src_valid), .src_en(src_en), .dom_sel(dom_sel),
    .busy(busy), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dom_sel", dom_sel, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 src_en", src_en, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 8; r++) begin
      wr(0, r);
      chk("R2 run write", dom_sel, r);
      chk("R3 idle enables", src_en, 1 << r);
    end

    for (int r = 0; r < 8; r++) begin
      for (int w = 0; w < 8; w++) begin
        wr(0, r);
        wr(1, w);
        pulse();
        chk("R5 busy set", busy, 1);
        chk("R5 old held", dom_sel, r);
        chk("R3 target enabled", src_en, (1 << r) | (1 << w));
        repeat (2) @(negedge clk);
        chk("R5 still waiting", busy, 1);
        src_valid = 8'(1 << w);
        @(negedge clk);
        chk("R5 switched", dom_sel, w);
        chk("R5 busy clear", busy, 0);
        chk("R3 after switch", src_en, 1 << w);
        src_valid = '0;
      end
    end

    for (int w = 0; w < 8; w++) begin
      wr(0, (w + 3) % 8);
      wr(1, w);
      wr(3, 1 << w);
      src_valid = 8'(1 << w);
      pulse();
      chk("R4 fast switch", dom_sel, w);
      chk("R4 no busy", busy, 0);
      src_valid = '0;
      wr(3, 0);
    end

    wr(0, 2); wr(1, 6); wr(2, 5);
    pulse();
    chk("R8 busy", busy, 1);
    repeat (4) @(negedge clk);
    chk("R8 busy at edge 4", busy, 1);
    chk("R8 no err yet", err, 0);
    @(negedge clk);
    chk("R8 err set", err, 1);
    chk("R8 busy clear", busy, 0);
    chk("R8 old source kept", dom_sel, 2);
    chk("R8 enables back", src_en, 1 << 2);
    src_valid = 8'h40;
    repeat (3) @(negedge clk);
    chk("R8 late valid ignored", dom_sel, 2);
    wr(3, 8'h40);
    pulse();
    chk("R9 err cleared", err, 0);
    chk("R9 fast after err", dom_sel, 6);
    src_valid = '0;
    wr(3, 0);

    wr(2, 0); wr(0, 1); wr(1, 5);
    pulse();
    repeat (60) @(negedge clk);
    chk("R8 no limit waits", busy, 1);
    chk("R8 no limit no err", err, 0);
    src_valid = 8'h20;
    @(negedge clk);
    chk("R8 no limit switch", dom_sel, 5);
    src_valid = '0;

    wr(0, 0); wr(1, 3);
    pulse();
    wr(1, 4);
    pulse();
    wr(0, 7);
    chk("R7 run write ignored", dom_sel, 0);
    chk("R6 still busy", busy, 1);
    src_valid = 8'h10;
    repeat (2) @(negedge clk);
    chk("R6 target unchanged", busy, 1);
    chk("R6 sel held", dom_sel, 0);
    src_valid = 8'h08;
    @(negedge clk);
    chk("R6 switched to first target", dom_sel, 3);
    src_valid = '0;
    pulse();
    chk("R6 new wake value used", src_en, (1 << 3) | (1 << 4));
    src_valid = 8'h10;
    @(negedge clk);
    chk("R6 second switch", dom_sel, 4);
    src_valid = '0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule